// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This unit adds or subtracts two 32-bit words as a set of independent lanes, either two 16-bit lanes or four 8-bit lanes. Each operation is plain (modular), saturating or halving. The opcode picks add or subtract and whether the halving form is wanted. A two-bit mode field picks plain or saturating for the non-halving forms.

Lane width and signedness are not carried by the opcode. The unit works them out from the range that the three 5-bit register indices fall in, all three together. The destination index and both source indices go with every operation. The register file stays outside the block: the caller supplies the operand words and the indices, and collects the result one cycle later.

A request whose indices do not agree on one range, or whose opcode and mode pair is undefined, is reported as illegal and produces a zero result.

Top module: `simd_addsub_unit`

## Requirements
- R1: When the three indices all lie in 16..29, the words are treated as two 16-bit lanes: bits [15:0] and bits [31:16].
- R2: When the three indices all lie in 2..15, the words are treated as four 8-bit lanes, one per byte.
- R3: For the saturating and halving forms, the indices must all lie in one sub-range, which sets the arithmetic. Indices 16..23 give signed 16-bit lanes. Indices 24..29 give unsigned 16-bit lanes. Indices 2..7 give signed 8-bit lanes. Indices 8..15 give unsigned 8-bit lanes.
- R4: Opcode 0 is add and opcode 1 is subtract. With mode 00, each lane result is (a+b) or (a-b) modulo 2^lane-width.
- R5: With opcode 0 or 1 and mode 01, each lane result is clamped to the lane's range. The signed range is -2^(W-1)..2^(W-1)-1 and the unsigned range is 0..2^W-1.
- R6: `sat_flag` is 1 when at least one lane was clamped in a saturating operation. For every other operation it is 0.
- R7: Opcode 2 is halving add and opcode 3 is halving subtract, both with mode 00. Each lane result is floor((a±b)/2), computed without losing the carry, and taken modulo 2^W.
- R8: A request is illegal when any of these holds:
  - the indices fall in mixed ranges, or any index is 0, 1, 30 or 31;
  - the mode is 10 or 11;
  - the opcode is a halving opcode and the mode is 01.
  An illegal request gives `illegal`=1, `result`=0 and `sat_flag`=0.
- R9: `out_valid` equals `in_valid` delayed by exactly one clock. The result of a request accepted at one edge appears after that edge.
- R10: While `in_valid` is 0, `result`, `sat_flag` and `illegal` keep their last values.
- R11: Synchronous reset clears `out_valid`, `result`, `sat_flag` and `illegal` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| opcode | input | 2 | 0 add, 1 sub, 2 halving add, 3 halving sub |
| mode | input | 2 | 00 plain, 01 saturating |
| idx_d | input | 5 | Destination register index |
| idx_a | input | 5 | First source register index |
| idx_b | input | 5 | Second source register index |
| opnd_a | input | 32 | First operand word |
| opnd_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Packed lane results |
| sat_flag | output | 1 | A lane was clamped |
| illegal | output | 1 | Request was rejected |

## Verification
The unit holds no state between requests apart from its output registers. A decode or lane fault therefore shows at the ports on the very cycle after the faulty request.

Some faults act only at lane boundaries: a carry crossing into the next lane, a wrong sign extension, or a clamp to the wrong bound. Those appear only for operands near 0, the sign boundary or all ones. The sweeps concentrate on such values and run every pair of byte values for two of the signed/unsigned classes.

A wrong range decision can show up two ways at the next output: `illegal` set when it should be clear (or the reverse), or lanes that are correct in value but have the wrong width.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_HADD = 2'd2,
    OP_HSUB = 2'd3
  } simd_op_e;

  typedef enum logic [1:0] {
    K_WRAP = 2'd0,
    K_SAT  = 2'd1,
    K_HALF = 2'd2,
    K_BAD  = 2'd3
  } lane_kind_e;

  typedef struct packed {
    logic       legal;
    logic       wide;
    logic       sgn;
    lane_kind_e kind;
  } simd_ctl_t;

  // Index ranges that carry lane width and signedness
  localparam int WIDE_LO      = 16;
  localparam int WIDE_USPLIT  = 24;
  localparam int WIDE_HI      = 29;
  localparam int NARROW_LO    = 2;
  localparam int NARROW_USPLIT = 8;
  localparam int NARROW_HI    = 15;
endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [1:0]       opcode,
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] idx_d,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  output simd_ctl_t        ctl
);
  function automatic logic all_in(input int lo, input int hi,
                                  input logic [IDX_W-1:0] x0,
                                  input logic [IDX_W-1:0] x1,
                                  input logic [IDX_W-1:0] x2);
    return (int'(x0) >= lo) && (int'(x0) <= hi) &&
           (int'(x1) >= lo) && (int'(x1) <= hi) &&
           (int'(x2) >= lo) && (int'(x2) <= hi);
  endfunction

  logic wide_any, narrow_any, wide_s, wide_u, narrow_s, narrow_u;
  logic signed_class, any_class;

  always_comb begin
    wide_any   = all_in(WIDE_LO, WIDE_HI, idx_d, idx_a, idx_b);
    narrow_any = all_in(NARROW_LO, NARROW_HI, idx_d, idx_a, idx_b);
    wide_s     = all_in(WIDE_LO, WIDE_USPLIT - 1, idx_d, idx_a, idx_b);
    wide_u     = all_in(WIDE_USPLIT, WIDE_HI, idx_d, idx_a, idx_b);
    narrow_s   = all_in(NARROW_LO, NARROW_USPLIT - 1, idx_d, idx_a, idx_b);
    narrow_u   = all_in(NARROW_USPLIT, NARROW_HI, idx_d, idx_a, idx_b);
    signed_class = wide_s | narrow_s;
    any_class    = wide_s | wide_u | narrow_s | narrow_u;

    ctl.legal = 1'b0;
    ctl.wide  = 1'b0;
    ctl.sgn   = 1'b0;
    ctl.kind  = K_BAD;
    if (!opcode[1] && mode == 2'b00) begin
      ctl.kind  = K_WRAP;
      ctl.legal = wide_any | narrow_any;
      ctl.wide  = wide_any;
    end else if (!opcode[1] && mode == 2'b01) begin
      ctl.kind  = K_SAT;
      ctl.legal = any_class;
      ctl.wide  = wide_s | wide_u;
      ctl.sgn   = signed_class;
    end else if (opcode[1] && mode == 2'b00) begin
      ctl.kind  = K_HALF;
      ctl.legal = any_class;
      ctl.wide  = wide_s | wide_u;
      ctl.sgn   = signed_class;
    end
  end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_sub,
  input  logic         is_signed,
  input  lane_kind_e   kind,
  output logic [W-1:0] y,
  output logic         clamped
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ax, bx, s;

  always_comb begin
    ax = {is_signed & a[W-1], a};
    bx = {is_signed & b[W-1], b};
    s  = is_sub ? (ax - bx) : (ax + bx);
    y       = s[W-1:0];
    clamped = 1'b0;
    case (kind)
      K_SAT: begin
        if (is_signed) begin
          if (s[W] != s[W-1]) begin
            clamped = 1'b1;
            y = s[W] ? SMIN : SMAX;
          end
        end else if (s[W]) begin
          clamped = 1'b1;
          y = is_sub ? '0 : '1;
        end
      end
      K_HALF:  y = s[W:1];
      default: y = s[W-1:0];
    endcase
  end
endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        opcode,
  input  logic [1:0]        mode,
  input  logic [IDX_W-1:0]  idx_d,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              sat_flag,
  output logic              illegal
);
  localparam int NW = DATA_W / WIDE_W;
  localparam int NN = DATA_W / NARROW_W;

  simd_ctl_t ctl;

  simd_decode #(.IDX_W(IDX_W)) u_dec (
    .opcode(opcode), .mode(mode),
    .idx_d(idx_d), .idx_a(idx_a), .idx_b(idx_b),
    .ctl(ctl)
  );

  logic [DATA_W-1:0] y_wide, y_narrow;
  logic [NW-1:0]     clamp_w;
  logic [NN-1:0]     clamp_n;

  for (genvar g = 0; g < NW; g++) begin : g_wide
    simd_lane #(.W(WIDE_W)) u_lane (
      .a(opnd_a[g*WIDE_W +: WIDE_W]), .b(opnd_b[g*WIDE_W +: WIDE_W]),
      .is_sub(opcode[0]), .is_signed(ctl.sgn), .kind(ctl.kind),
      .y(y_wide[g*WIDE_W +: WIDE_W]), .clamped(clamp_w[g])
    );
  end

  for (genvar g = 0; g < NN; g++) begin : g_narrow
    simd_lane #(.W(NARROW_W)) u_lane (
      .a(opnd_a[g*NARROW_W +: NARROW_W]), .b(opnd_b[g*NARROW_W +: NARROW_W]),
      .is_sub(opcode[0]), .is_signed(ctl.sgn), .kind(ctl.kind),
      .y(y_narrow[g*NARROW_W +: NARROW_W]), .clamped(clamp_n[g])
    );
  end

  logic [DATA_W-1:0] res_sel;
  logic              sat_any;

  always_comb begin
    res_sel = ctl.wide ? y_wide : y_narrow;
    sat_any = (ctl.kind == K_SAT) && (ctl.wide ? (|clamp_w) : (|clamp_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= ctl.legal ? res_sel : '0;
        sat_flag <= ctl.legal & sat_any;
        illegal  <= ~ctl.legal;
      end
    end
  end
endmodule

// File: rtl/simd_addsub_checker.sv
module simd_addsub_checker
  import simd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIDE_W = 16,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        opcode,
  input logic [1:0]        mode,
  input logic [IDX_W-1:0]  idx_d,
  input logic [IDX_W-1:0]  idx_a,
  input logic [IDX_W-1:0]  idx_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              sat_flag,
  input logic              illegal
);
  logic [WIDE_W-1:0] lo_sum;
  logic              wide_req;

  always_comb begin
    lo_sum   = opnd_a[WIDE_W-1:0] + opnd_b[WIDE_W-1:0];
    wide_req = (int'(idx_d) >= WIDE_LO) && (int'(idx_d) <= WIDE_HI) &&
               (int'(idx_a) >= WIDE_LO) && (int'(idx_a) <= WIDE_HI) &&
               (int'(idx_b) >= WIDE_LO) && (int'(idx_b) <= WIDE_HI);
  end

  // R4 with R1: plain add on wide lanes gives modular sum in the low lane
  p_wrap_low_lane_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 2'd0 && mode == 2'b00 && wide_req)
      |=> (result[WIDE_W-1:0] == $past(lo_sum) && !illegal));

  // R6: no saturation report outside the saturating forms
  p_sat_only_in_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(!opcode[1] && mode == 2'b01)) |=> !sat_flag);

  // R8: undefined mode values are rejected with a zero result
  p_bad_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[1]) |=> (illegal && result == '0 && !sat_flag));

  // R8: an illegal result never carries data or a clamp report
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == '0 && !sat_flag));

  // R9: valid strobe follows the request by one clock
  p_valid_on_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_off_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10: outputs hold between requests
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(sat_flag) && $stable(illegal)));
endmodule

bind simd_addsub_unit simd_addsub_checker #(
  .DATA_W(DATA_W), .WIDE_W(WIDE_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .mode(mode),
  .idx_d(idx_d), .idx_a(idx_a), .idx_b(idx_b),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
  .result(result), .sat_flag(sat_flag), .illegal(illegal)
);

// File: tb/simd_addsub_unit_test.sv
module simd_addsub_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  opcode = '0;
  logic [1:0]  mode = '0;
  logic [4:0]  idx_d = '0, idx_a = '0, idx_b = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        out_valid, sat_flag, illegal;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  simd_addsub_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .mode(mode),
    .idx_d(idx_d), .idx_a(idx_a), .idx_b(idx_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
    .result(result), .sat_flag(sat_flag), .illegal(illegal)
  );

  function automatic bit rng3(input int lo, input int hi, input int d, input int a, input int b);
    return d >= lo && d <= hi && a >= lo && a <= hi && b >= lo && b <= hi;
  endfunction

  // Reference model built from R1..R8; returns {illegal, sat, result}
  function automatic logic [33:0] model(input logic [1:0] op, input logic [1:0] md,
                                        input int d, input int s1, input int s2,
                                        input logic [31:0] a, input logic [31:0] b,
                                        output string tag);
    bit legal = 0, wide = 0, sgn = 0;
    int kind = 3; // 0 plain, 1 saturate, 2 halve
    int w, n;
    longint mask, half, full, x, y, r, lo, hi;
    logic [31:0] res = '0;
    logic sat = 1'b0;
    bit ws = rng3(16, 23, d, s1, s2), wu = rng3(24, 29, d, s1, s2);
    bit ns = rng3(2, 7, d, s1, s2),   nu = rng3(8, 15, d, s1, s2);
    if (!op[1] && md == 2'b00) begin
      kind = 0; wide = rng3(16, 29, d, s1, s2);
      legal = wide || rng3(2, 15, d, s1, s2);
    end else if ((!op[1] && md == 2'b01) || (op[1] && md == 2'b00)) begin
      kind = op[1] ? 2 : 1;
      legal = ws || wu || ns || nu; wide = ws || wu; sgn = ws || ns;
    end
    if (!legal) begin
      tag = "R8";
      return {1'b1, 1'b0, 32'h0};
    end
    tag = (kind == 0) ? "R4" : (kind == 1) ? "R5/R3" : "R7/R3";
    tag = {tag, wide ? "/R1" : "/R2"};
    w = wide ? 16 : 8;
    n = 32 / w;
    full = longint'(1) << w;
    half = full >> 1;
    mask = full - 1;
    for (int l = 0; l < n; l++) begin
      x = (longint'(a) >> (l*w)) & mask;
      y = (longint'(b) >> (l*w)) & mask;
      if (sgn && x >= half) x = x - full;
      if (sgn && y >= half) y = y - full;
      r = op[0] ? x - y : x + y;
      if (kind == 1) begin
        lo = sgn ? -half : 0;
        hi = sgn ? half - 1 : full - 1;
        if (r > hi) begin r = hi; sat = 1'b1; end
        if (r < lo) begin r = lo; sat = 1'b1; end
      end else if (kind == 2) begin
        r = r >>> 1;
      end
      res = res | 32'((r & mask) << (l*w));
    end
    return {1'b0, sat, res};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] md,
                       input int d, input int s1, input int s2,
                       input logic [31:0] a, input logic [31:0] b);
    logic [33:0] exp;
    string tag;
    exp = model(op, md, d, s1, s2, a, b, tag);
    @(negedge clk);
    opcode = op; mode = md;
    idx_d = 5'(d); idx_a = 5'(s1); idx_b = 5'(s2);
    opnd_a = a; opnd_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // R9: result visible one edge after the request
    check(out_valid === 1'b1, "R9", "out_valid", 32'(out_valid), 32'd1);
    check(result === exp[31:0] && illegal === exp[33], tag, "result/illegal",
          result, exp[31:0]);
    // R6: clamp report
    check(sat_flag === exp[32], "R6", "sat_flag", 32'(sat_flag), 32'(exp[32]));
  endtask

  logic [15:0] edges [8];
  int triples [12][3];

  initial begin
    edges = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h8001, 16'h7FFE, 16'h12F3};
    triples = '{'{16, 20, 29}, '{16, 17, 23}, '{24, 25, 29}, '{2, 3, 7},
                '{8, 9, 15}, '{2, 15, 10}, '{16, 24, 20}, '{5, 16, 20},
                '{0, 2, 3}, '{30, 16, 17}, '{1, 8, 9}, '{31, 31, 31}};
    repeat (3) @(negedge clk);
    // R11: reset state
    check(out_valid === 1'b0 && result === 32'h0 && sat_flag === 1'b0 && illegal === 1'b0,
          "R11", "reset outputs", result, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R9", "idle out_valid", 32'(out_valid), 32'd0);

    // Sweep: every opcode, mode and index class against boundary operands
    // (R1 R2 R3 R4 R5 R6 R7 R8)
    for (int op = 0; op < 4; op++)
      for (int md = 0; md < 4; md++)
        for (int t = 0; t < 12; t++)
          for (int i = 0; i < 8; i++)
            for (int k = 0; k < 8; k++)
              issue(2'(op), 2'(md), triples[t][0], triples[t][1], triples[t][2],
                    {edges[i], edges[k]}, {edges[k], edges[i][7:0], edges[i][15:8]});

    // R10: outputs hold while no request is presented
    issue(2'd0, 2'b01, 16, 17, 23, 32'h7FFF_0001, 32'h0001_0001);
    @(negedge clk);
    opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h1234_5678; mode = 2'b11;
    repeat (2) @(negedge clk);
    check(result === 32'h7FFF_0002 && sat_flag === 1'b1 && illegal === 1'b0 && out_valid === 1'b0,
          "R10", "held result", result, 32'h7FFF_0002);

    // Exhaustive byte pairs: signed saturating add (R5, R3, R2)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 64; b++)
        issue(2'd0, 2'b01, 2, 3, 7, {4{8'(a)}},
              {8'(b + 192), 8'(b + 128), 8'(b + 64), 8'(b)});
    // Exhaustive byte pairs: unsigned halving subtract (R7, R3, R2)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 64; b++)
        issue(2'd3, 2'b00, 8, 9, 15, {4{8'(a)}},
              {8'(b + 192), 8'(b + 128), 8'(b + 64), 8'(b)});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule